// File: doc/BRIEF.md
# Prioritized Trigger Source Arbiter

This block sits in front of a single ADC conversion sequencer and decides which of ten trigger sources it serves next. Sources 0 to 7 are general triggers. Each general trigger can take its request from an external pin or, in software mode, from a one-shot write strobe. Sources 8 and 9 are touch-screen triggers, and they take requests from their pins only. A request is held in a per-source pending latch until it wins arbitration. Each source has its own 3-bit priority.

When the sequencer is idle, the highest-priority pending source that is enabled is granted. The grant is a one-cycle `grant_valid` pulse together with the source number on `grant_idx`. A bypass control takes the touch-screen class out of arbitration entirely and routes those pins straight to a direct output. Out of reset the configuration inputs are expected to hold: bypass on, touch-screen enables off, general mask zero, and all priorities zero.

Top module: `trig_arbiter`

## Requirements
- R1: After reset, `grant_valid` is 0, no source is pending, and `ts_direct` is 0 while the touch-screen pins are low.
- R2: A hardware-mode source latches a request on a 0-to-1 transition of its pin. With the sequencer idle, the grant appears after the second rising clock edge that follows the transition. A pin held high produces only one grant.
- R3: When `gen_sw_mode[i]` is 1, the pin of general trigger i is ignored. A one-cycle `sw_trig_wr[i]` pulse produces exactly one grant of index i, after the third clock edge. The software strobe clears itself after one cycle.
- R4: General trigger i takes part only while `gen_en_mask[i]` is 1 (bit 0 is trigger 0, bit 7 is trigger 7). A request is not latched while the trigger is disabled. Disabling a trigger discards its pending request, and a disabled source is never granted.
- R5: Among eligible pending sources, the one with the highest priority wins. The priority of source s is `prio_flat[3*s+2:3*s]`, where 7 is the highest and 0 the lowest.
- R6: When eligible pending sources share the highest priority, the lowest index wins.
- R7: No grant is issued in a cycle that follows a clock edge at which `seq_busy` was 1. Pending requests are kept and are granted once `seq_busy` falls.
- R8: Touch-screen triggers 8 and 9 work in hardware mode only. They are enabled by `ts_en[0]` and `ts_en[1]` respectively, take part in arbitration when bypass is off, and are unaffected by `gen_sw_mode`.
- R9: While `ts_bypass` is 1, `ts_direct` equals `ts_trig_in`, `ts_en` has no effect, and sources 8 and 9 are never granted. While `ts_bypass` is 0, `ts_direct` is 0.
- R10: At most one source is granted per cycle, and `grant_idx` is always below 10 when valid. The winner's pending request is cleared, so the remaining pending sources are granted in the following idle cycles, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_trig_in | input | 8 | External pins of general triggers 0..7 |
| ts_trig_in | input | 2 | External pins of touch-screen triggers (bit 0 is source 8) |
| gen_en_mask | input | 8 | Enable per general trigger |
| gen_sw_mode | input | 8 | Software mode select per general trigger |
| sw_trig_wr | input | 8 | One-cycle software trigger strobe per general trigger |
| ts_en | input | 2 | Touch-screen trigger enables (count only with bypass off) |
| ts_bypass | input | 1 | Routes touch-screen pins to `ts_direct` instead of arbitration |
| prio_flat | input | 30 | 3-bit priority per source, source s at bits 3s+2..3s |
| seq_busy | input | 1 | Sequencer busy; blocks new grants |
| grant_valid | output | 1 | One-cycle grant strobe |
| grant_idx | output | 4 | Granted source number 0..9 |
| ts_direct | output | 2 | Touch-screen pins passed through under bypass |

## Verification
The bench targets the priority comparison and the tie rule. A strict-versus-non-strict slip in the comparison would let the highest index win ties, and it also checks that the top priority value 7 beats everything. It checks that a held pin yields a single grant and that a software-mode source ignores its pin, since a level-sensitive latch would re-grant every idle cycle. It also confirms that disabling a source drops its pending request, and that bypass keeps sources 8 and 9 out of the grant stream while still passing their pins through. A drain count after each vector checks that a winner's pending bit is cleared, so every other pending source is served exactly once.

// File: rtl/trig_arb_pkg.sv
// Package: default sizes shared by the trigger arbiter and its checker.
package trig_arb_pkg;
    localparam int DEF_GEN_N  = 8;
    localparam int DEF_TS_N   = 2;
    localparam int DEF_PRIO_W = 3;
endpackage

// File: rtl/trig_req_latch.sv
// trig_req_latch: edge detect or software strobe feeding one pending latch.
// Assumes the pin is synchronous to clk. Set beats a same-cycle grant clear.
module trig_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_in,
    input  logic sw_mode,
    input  logic sw_pulse,
    input  logic enable,
    input  logic grant_clr,
    output logic pending
);
    logic hw_q;
    logic sw_q;
    logic req;

    // Select the request source: strobe copy in software mode, pin edge otherwise.
    always_comb req = sw_mode ? sw_q : (hw_in & ~hw_q);

    // Hold the previous pin level, the self-clearing strobe copy and the pending latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_q    <= 1'b0;
            sw_q    <= 1'b0;
            pending <= 1'b0;
        end else begin
            hw_q    <= hw_in;
            sw_q    <= sw_pulse & sw_mode;
            pending <= enable & ((pending & ~grant_clr) | req);
        end
    end
endmodule

// File: rtl/prio_pick.sv
// prio_pick: combinational selection of the highest-priority eligible source.
// A strict comparison in ascending index order makes the lowest index win ties.
module prio_pick #(
    parameter int SRC_N  = 10,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = $clog2(SRC_N)
) (
    input  logic [SRC_N-1:0]        elig,
    input  logic [SRC_N*PRIO_W-1:0] prio_flat,
    output logic                    any,
    output logic [IDX_W-1:0]        win_idx
);
    logic [PRIO_W-1:0] best_p;

    // Scan all sources and keep the first one seen with the strictly largest priority.
    always_comb begin
        any     = 1'b0;
        win_idx = '0;
        best_p  = '0;
        for (int s = 0; s < SRC_N; s++) begin
            if (elig[s] && (!any || prio_flat[s*PRIO_W +: PRIO_W] > best_p)) begin
                any     = 1'b1;
                win_idx = IDX_W'(s);
                best_p  = prio_flat[s*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/grant_stage.sv
// grant_stage: registers the grant strobe and index, and clears the winner's latch.
// Assumes seq_busy comes from a register in the sequencer.
module grant_stage #(
    parameter int SRC_N = 10,
    parameter int IDX_W = $clog2(SRC_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any,
    input  logic [IDX_W-1:0] win_idx,
    input  logic             seq_busy,
    output logic [SRC_N-1:0] grant_clr,
    output logic             grant_valid,
    output logic [IDX_W-1:0] grant_idx
);
    logic fire;

    // A grant fires when something is eligible and the sequencer is idle.
    always_comb begin
        fire      = any & ~seq_busy;
        grant_clr = '0;
        if (fire) grant_clr[win_idx] = 1'b1;
    end

    // Register the grant outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_idx   <= '0;
        end else begin
            grant_valid <= fire;
            if (fire) grant_idx <= win_idx;
        end
    end
endmodule

// File: rtl/trig_arbiter.sv
// trig_arbiter: ten-source trigger arbiter in front of one ADC sequencer.
// General triggers [GEN_N-1:0] support software mode. Touch-screen triggers
// follow them, work in hardware mode only, and can bypass arbitration.
module trig_arbiter #(
    parameter int GEN_N  = trig_arb_pkg::DEF_GEN_N,
    parameter int TS_N   = trig_arb_pkg::DEF_TS_N,
    parameter int PRIO_W = trig_arb_pkg::DEF_PRIO_W,
    localparam int SRC_N = GEN_N + TS_N,
    localparam int IDX_W = $clog2(SRC_N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [GEN_N-1:0]        gen_trig_in,
    input  logic [TS_N-1:0]         ts_trig_in,
    input  logic [GEN_N-1:0]        gen_en_mask,
    input  logic [GEN_N-1:0]        gen_sw_mode,
    input  logic [GEN_N-1:0]        sw_trig_wr,
    input  logic [TS_N-1:0]         ts_en,
    input  logic                    ts_bypass,
    input  logic [SRC_N*PRIO_W-1:0] prio_flat,
    input  logic                    seq_busy,
    output logic                    grant_valid,
    output logic [IDX_W-1:0]        grant_idx,
    output logic [TS_N-1:0]         ts_direct
);
    logic [SRC_N-1:0] en_vec;
    logic [SRC_N-1:0] pending;
    logic [SRC_N-1:0] elig;
    logic [SRC_N-1:0] grant_clr;
    logic             any;
    logic [IDX_W-1:0] win_idx;

    // Build the per-source enables; the touch-screen enables count only without bypass.
    always_comb begin
        en_vec = {ts_en & {TS_N{~ts_bypass}}, gen_en_mask};
        elig   = pending & en_vec;
    end

    // Pass the touch-screen pins straight through while bypass is on.
    always_comb ts_direct = ts_bypass ? ts_trig_in : '0;

    // One request latch per source; touch-screen latches are tied to hardware mode.
    for (genvar s = 0; s < SRC_N; s++) begin : g_src
        if (s < GEN_N) begin : g_gen
            trig_req_latch u_lat (
                .clk(clk), .rst_n(rst_n),
                .hw_in(gen_trig_in[s]), .sw_mode(gen_sw_mode[s]),
                .sw_pulse(sw_trig_wr[s]), .enable(en_vec[s]),
                .grant_clr(grant_clr[s]), .pending(pending[s])
            );
        end else begin : g_ts
            trig_req_latch u_lat (
                .clk(clk), .rst_n(rst_n),
                .hw_in(ts_trig_in[s-GEN_N]), .sw_mode(1'b0),
                .sw_pulse(1'b0), .enable(en_vec[s]),
                .grant_clr(grant_clr[s]), .pending(pending[s])
            );
        end
    end

    prio_pick #(.SRC_N(SRC_N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
        .elig(elig), .prio_flat(prio_flat), .any(any), .win_idx(win_idx)
    );

    grant_stage #(.SRC_N(SRC_N), .IDX_W(IDX_W)) u_grant (
        .clk(clk), .rst_n(rst_n), .any(any), .win_idx(win_idx),
        .seq_busy(seq_busy), .grant_clr(grant_clr),
        .grant_valid(grant_valid), .grant_idx(grant_idx)
    );
endmodule

// File: rtl/trig_arbiter_chk.sv
// trig_arbiter_chk: temporal properties of the arbiter, attached with bind.
// Assumes the same parameters as the arbiter it watches.
module trig_arbiter_chk #(
    parameter int GEN_N  = 8,
    parameter int TS_N   = 2,
    parameter int PRIO_W = 3,
    localparam int SRC_N = GEN_N + TS_N,
    localparam int IDX_W = $clog2(SRC_N),
    localparam int GIX_W = $clog2(GEN_N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [GEN_N-1:0] gen_en_mask,
    input logic             ts_bypass,
    input logic             seq_busy,
    input logic             grant_valid,
    input logic [IDX_W-1:0] grant_idx
);
    logic [GEN_N-1:0] en_q;
    logic             byp_q;

    // Remember the enables and bypass seen at the edge that decided the current grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            byp_q <= 1'b1;
        end else begin
            en_q  <= gen_en_mask;
            byp_q <= ts_bypass;
        end
    end

    // R7
    busy_blocks_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> !grant_valid);

    // R10
    grant_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_idx < IDX_W'(SRC_N)));

    // R4
    disabled_never_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_idx < IDX_W'(GEN_N)) |-> en_q[grant_idx[GIX_W-1:0]]);

    // R9
    bypass_blocks_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byp_q |-> !(grant_valid && grant_idx >= IDX_W'(GEN_N)));
endmodule

bind trig_arbiter trig_arbiter_chk #(.GEN_N(GEN_N), .TS_N(TS_N), .PRIO_W(PRIO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .gen_en_mask(gen_en_mask), .ts_bypass(ts_bypass),
    .seq_busy(seq_busy), .grant_valid(grant_valid), .grant_idx(grant_idx)
);

// File: tb/tb_trig_arbiter.sv
`timescale 1ns/1ps
module tb_trig_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  gen_trig_in = '0;
    logic [1:0]  ts_trig_in = '0;
    logic [7:0]  gen_en_mask = '0;
    logic [7:0]  gen_sw_mode = '0;
    logic [7:0]  sw_trig_wr = '0;
    logic [1:0]  ts_en = '0;
    logic        ts_bypass = 1'b1;
    logic [29:0] prio_flat = '0;
    logic        seq_busy = 1'b0;
    logic        grant_valid;
    logic [3:0]  grant_idx;
    logic [1:0]  ts_direct;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    trig_arbiter dut (.*);

    // Vector: {trig[9:0], base_prio[2:0], special_src[3:0], special_prio[2:0], expected_idx[3:0]}
    localparam logic [23:0] VEC [8] = '{
        {10'b0000001000, 3'd0, 4'd3, 3'd0, 4'd3},
        {10'b0000100010, 3'd2, 4'd5, 3'd4, 4'd5},
        {10'b0001000100, 3'd3, 4'd2, 3'd3, 4'd2},
        {10'b0100000001, 3'd0, 4'd8, 3'd7, 4'd8},
        {10'b1010000000, 3'd7, 4'd0, 3'd7, 4'd7},
        {10'b1111111111, 3'd0, 4'd0, 3'd0, 4'd0},
        {10'b1111111111, 3'd0, 4'd9, 3'd1, 4'd9},
        {10'b0001010000, 3'd6, 4'd6, 3'd7, 4'd6}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic watch(input int n, output int cnt, output int last);
        cnt = 0;
        last = -1;
        repeat (n) begin
            @(negedge clk);
            if (grant_valid) begin
                cnt++;
                last = int'(grant_idx);
            end
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int cnt;
        int last;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(grant_valid == 1'b0, "R1 grant_valid after reset", int'(grant_valid), 0);
        check(ts_direct == 2'b00, "R1 ts_direct after reset", int'(ts_direct), 0);
        watch(4, cnt, last);
        check(cnt == 0, "R1 no grant when idle", cnt, 0);

        gen_en_mask = 8'hFF;
        ts_en = 2'b11;
        ts_bypass = 1'b0;

        // R5 R6 R7 R8 R10: table of vectors
        for (int v = 0; v < 8; v++) begin
            logic [9:0] trig;
            int exp_idx;
            trig = VEC[v][23:14];
            exp_idx = int'(VEC[v][3:0]);
            @(negedge clk);
            seq_busy = 1'b1;
            for (int s = 0; s < 10; s++) prio_flat[s*3 +: 3] = VEC[v][13:11];
            prio_flat[int'(VEC[v][10:7])*3 +: 3] = VEC[v][6:4];
            gen_trig_in = trig[7:0];
            ts_trig_in = trig[9:8];
            @(negedge clk);
            gen_trig_in = '0;
            ts_trig_in = '0;
            @(negedge clk);
            check(grant_valid == 1'b0, "R7 no grant while busy", int'(grant_valid), 0);
            seq_busy = 1'b0;
            @(negedge clk);
            check(grant_valid == 1'b1 && int'(grant_idx) == exp_idx,
                  "R5/R6 winner index", int'(grant_idx), exp_idx);
            watch(12, cnt, last);
            check(cnt == $countones(trig) - 1, "R10 drain one grant per source",
                  cnt, $countones(trig) - 1);
        end
        prio_flat = '0;

        // R2: held level grants once
        @(negedge clk);
        gen_trig_in[2] = 1'b1;
        watch(2, cnt, last);
        check(cnt == 1 && last == 2, "R2 grant after second edge", last, 2);
        watch(5, cnt, last);
        check(cnt == 0, "R2 held pin no regrant", cnt, 0);
        gen_trig_in[2] = 1'b0;

        // R3: software mode ignores the pin, strobe grants once
        @(negedge clk);
        gen_sw_mode[1] = 1'b1;
        gen_trig_in[1] = 1'b1;
        watch(5, cnt, last);
        check(cnt == 0, "R3 pin ignored in software mode", cnt, 0);
        gen_trig_in[1] = 1'b0;
        sw_trig_wr[1] = 1'b1;
        @(negedge clk);
        sw_trig_wr[1] = 1'b0;
        watch(1, cnt, last);
        check(cnt == 0, "R3 no grant before third edge", cnt, 0);
        watch(1, cnt, last);
        check(cnt == 1 && last == 1, "R3 software grant index", last, 1);
        watch(5, cnt, last);
        check(cnt == 0, "R3 strobe self-clears", cnt, 0);
        gen_sw_mode = '0;

        // R4: disabled source not latched; disabling drops pending
        @(negedge clk);
        gen_en_mask[4] = 1'b0;
        gen_trig_in[4] = 1'b1;
        watch(4, cnt, last);
        check(cnt == 0, "R4 disabled source not granted", cnt, 0);
        gen_en_mask[4] = 1'b1;
        watch(4, cnt, last);
        check(cnt == 0, "R4 request not latched while disabled", cnt, 0);
        gen_trig_in[4] = 1'b0;
        seq_busy = 1'b1;
        gen_trig_in[3] = 1'b1;
        @(negedge clk);
        gen_trig_in[3] = 1'b0;
        gen_en_mask[3] = 1'b0;
        @(negedge clk);
        gen_en_mask[3] = 1'b1;
        seq_busy = 1'b0;
        watch(5, cnt, last);
        check(cnt == 0, "R4 disable drops pending", cnt, 0);

        // R8: touch-screen trigger unaffected by software mode bits
        gen_sw_mode = 8'hFF;
        ts_trig_in[1] = 1'b1;
        watch(4, cnt, last);
        check(cnt == 1 && last == 9, "R8 touch-screen hardware grant", last, 9);
        ts_trig_in[1] = 1'b0;
        gen_sw_mode = '0;
        ts_en = 2'b00;
        ts_trig_in[0] = 1'b1;
        watch(4, cnt, last);
        check(cnt == 0, "R8 ts_en off blocks source 8", cnt, 0);
        ts_trig_in[0] = 1'b0;
        check(ts_direct == 2'b00, "R9 no pass-through without bypass", int'(ts_direct), 0);

        // R9: bypass passes pins through and blocks arbitration
        ts_bypass = 1'b1;
        ts_en = 2'b11;
        @(negedge clk);
        ts_trig_in = 2'b01;
        #1;
        check(ts_direct == 2'b01, "R9 ts_direct follows pin", int'(ts_direct), 1);
        watch(5, cnt, last);
        check(cnt == 0, "R9 bypassed source never granted", cnt, 0);
        ts_trig_in = 2'b10;
        #1;
        check(ts_direct == 2'b10, "R9 ts_direct second pin", int'(ts_direct), 2);
        watch(5, cnt, last);
        check(cnt == 0, "R9 ts_en ignored under bypass", cnt, 0);
        ts_trig_in = '0;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule